// File: doc/BRIEF.md
# Station Address Learning Table

This block keeps the forwarding knowledge of a small multi-port switch. For every frame it receives a request with the source address, the destination address and the arrival port. It looks up both addresses in a direct-mapped store of station entries. Each entry holds a valid flag, the full 48-bit address, the port where the station was last seen, and a small age count. It returns one result per frame: an egress port, a flood indication, or a filter decision when the destination sits on the arrival port.

An unknown source address is not written straight away. The block holds the request open until the frame's end-of-frame status arrives, and it writes the entry only when that status reports a good frame. A known source address has its age cleared at once. A programmable timer starts background sweeps over the whole store. Each sweep ages every valid entry and removes the ones that have reached the oldest age. The controller is a four-state machine: IDLE takes requests, LOOK reads both entries, PEND waits for end-of-frame status, and SWEEP walks the store. Its transitions are IDLE→LOOK on an accepted request, IDLE→SWEEP when a sweep is due, LOOK→IDLE on a source hit, LOOK→PEND on a source miss, PEND→IDLE on end-of-frame status, and SWEEP→IDLE after the last index.

Top module: `mac_learn_table`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1 and `res_valid` is 0.
- R2: An address maps to index addr[9:0] XOR addr[19:10] (1024 entries). Learning an address whose index holds a different valid address replaces that entry.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `res_valid` is 1 for exactly one cycle, after the second rising edge from acceptance. `req_ready` is 0 from acceptance until the request is finished.
- R4: A destination found valid in the table on a port other than the arrival port gives `res_port` equal to the stored port, with `res_flood`=0 and `res_filter`=0.
- R5: A destination that is not in the table, or that has bit 40 set (group address, including broadcast), gives `res_flood`=1 and `res_filter`=0.
- R6: A destination found in the table on the arrival port gives `res_filter`=1 and `res_flood`=0.
- R7: On a source miss the block enters PEND and keeps `req_ready` at 0 until `eof_valid`. With `eof_good`=1 it writes the source address with the arrival port and age 0, and a later lookup of that address finds it.
- R8: A source miss closed with `eof_good`=0 leaves the table unchanged.
- R9: A source hit clears the entry's age to 0 without waiting for end-of-frame status (`req_ready` returns to 1 with the result). The stored port is not changed.
- R10: With `age_period`=P>0, a sweep starts after P cycles counted outside sweeps, and `req_ready` is 0 while it runs. The sweep adds 1 to the age of each valid entry and removes any entry whose age is already 3. A freshly learned entry therefore survives three sweeps and is gone after the fourth. P=0 stops sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_sa | input | 48 | Source address of the frame |
| req_da | input | 48 | Destination address of the frame |
| req_port | input | 3 | Arrival port |
| eof_valid | input | 1 | End-of-frame status strobe |
| eof_good | input | 1 | 1 when the frame ended without error |
| age_period | input | 32 | Cycles between sweeps, 0 disables aging |
| res_valid | output | 1 | Result strobe |
| res_flood | output | 1 | Send to all ports except arrival |
| res_filter | output | 1 | Drop: destination is on arrival port |
| res_port | output | 3 | Egress port when neither flood nor filter |

## Verification
The result is due two rising edges after the accepting edge. The bench drives inputs on falling edges and samples at the falling edge after each of those two rising edges: `res_valid` must be low at the first and high at the second. A learn write lands on the rising edge where `eof_valid` is seen in PEND. Its effect is checked only through a later lookup, which is itself sampled on the same two-edge schedule. Sweep effects are counted by watching `req_ready` drop and recover while no request is outstanding, and `age_period` is returned to 0 before any lookup, so no sweep can intrude on a checked request.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    localparam int MAC_W     = 48;
    localparam int PORT_W    = 3;
    localparam int AGE_W     = 2;
    localparam int GROUP_BIT = 40;

    typedef struct packed {
        logic              vld;
        logic [MAC_W-1:0]  mac;
        logic [PORT_W-1:0] port;
        logic [AGE_W-1:0]  age;
    } mlt_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_PEND,
        ST_SWEEP
    } mlt_state_t;
endpackage

// File: rtl/mlt_hash.sv
module mlt_hash #(
    parameter int IDX_W = 10
) (
    input  logic [2*IDX_W-1:0] key,
    output logic [IDX_W-1:0]   idx
);
    // fold two adjacent slices of the low address bits
    assign idx = key[IDX_W-1:0] ^ key[2*IDX_W-1:IDX_W];
endmodule

// File: rtl/mlt_store.sv
module mlt_store
    import mlt_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int IDX_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output mlt_entry_t       rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output mlt_entry_t       rd_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  mlt_entry_t       wr_ent
);
    logic [ENTRIES-1:0] vld_q;
    logic [MAC_W-1:0]   mac_mem  [ENTRIES];
    logic [PORT_W-1:0]  port_mem [ENTRIES];
    logic [AGE_W-1:0]   age_mem  [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_ent.vld;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mac_mem[wr_idx]  <= wr_ent.mac;
            port_mem[wr_idx] <= wr_ent.port;
            age_mem[wr_idx]  <= wr_ent.age;
        end
    end

    assign rd_a = '{vld: vld_q[rd_a_idx], mac: mac_mem[rd_a_idx],
                    port: port_mem[rd_a_idx], age: age_mem[rd_a_idx]};
    assign rd_b = '{vld: vld_q[rd_b_idx], mac: mac_mem[rd_b_idx],
                    port: port_mem[rd_b_idx], age: age_mem[rd_b_idx]};
endmodule

// File: rtl/mlt_age_timer.sv
module mlt_age_timer #(
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic                run,
    input  logic                start,
    output logic                due
);
    logic [PERIOD_W-1:0] cnt_q;
    logic                hit;

    assign hit = (period != '0) && (cnt_q >= period - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else begin
            if (period == '0) begin
                cnt_q <= '0;
            end else if (run) begin
                cnt_q <= hit ? '0 : cnt_q + 1'b1;
            end
            if (start) begin
                due <= 1'b0;
            end else if (run && hit) begin
                due <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table
    import mlt_pkg::*;
#(
    parameter int ENTRIES  = 1024,
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [47:0]         req_sa,
    input  logic [47:0]         req_da,
    input  logic [2:0]          req_port,
    input  logic                eof_valid,
    input  logic                eof_good,
    input  logic [PERIOD_W-1:0] age_period,
    output logic                res_valid,
    output logic                res_flood,
    output logic                res_filter,
    output logic [2:0]          res_port
);
    localparam int              IDX_W    = $clog2(ENTRIES);
    localparam int              KEY_W    = 2 * IDX_W;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    mlt_state_t        state_q, state_d;
    logic [MAC_W-1:0]  cur_sa, cur_da;
    logic [PORT_W-1:0] cur_port;
    logic [IDX_W-1:0]  sw_idx;
    logic [IDX_W-1:0]  sa_idx, da_idx, rd_a_idx;
    mlt_entry_t        rd_a, rd_b, wr_ent;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              sweep_due, sweep_start, accept;
    logic              sa_hit, da_hit, look_flood, look_filter;

    mlt_hash #(.IDX_W(IDX_W)) u_hash_sa (.key(cur_sa[KEY_W-1:0]), .idx(sa_idx));
    mlt_hash #(.IDX_W(IDX_W)) u_hash_da (.key(cur_da[KEY_W-1:0]), .idx(da_idx));

    assign rd_a_idx = (state_q == ST_SWEEP) ? sw_idx : sa_idx;

    mlt_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (rd_a_idx),
        .rd_a     (rd_a),
        .rd_b_idx (da_idx),
        .rd_b     (rd_b),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_ent   (wr_ent)
    );

    assign req_ready   = (state_q == ST_IDLE) && !sweep_due;
    assign accept      = req_valid && req_ready;
    assign sweep_start = (state_q == ST_IDLE) && sweep_due;

    mlt_age_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (age_period),
        .run    (state_q != ST_SWEEP),
        .start  (sweep_start),
        .due    (sweep_due)
    );

    assign sa_hit      = rd_a.vld && (rd_a.mac == cur_sa);
    assign da_hit      = rd_b.vld && (rd_b.mac == cur_da);
    assign look_flood  = cur_da[GROUP_BIT] || !da_hit;
    assign look_filter = !look_flood && (rd_b.port == cur_port);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_LOOK;
                end else if (sweep_due) begin
                    state_d = ST_SWEEP;
                end
            end
            ST_LOOK:  state_d = sa_hit ? ST_IDLE : ST_PEND;
            ST_PEND:  state_d = eof_valid ? ST_IDLE : ST_PEND;
            ST_SWEEP: state_d = (sw_idx == LAST_IDX) ? ST_IDLE : ST_SWEEP;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and sweep pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_sa   <= '0;
            cur_da   <= '0;
            cur_port <= '0;
            sw_idx   <= '0;
        end else begin
            if (accept) begin
                cur_sa   <= req_sa;
                cur_da   <= req_da;
                cur_port <= req_port;
            end
            if (state_q == ST_SWEEP) begin
                sw_idx <= sw_idx + 1'b1;
            end else begin
                sw_idx <= '0;
            end
        end
    end

    // table write port
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = sa_idx;
        wr_ent = rd_a;
        unique case (state_q)
            ST_LOOK: begin
                if (sa_hit) begin
                    wr_en      = 1'b1;
                    wr_ent.age = '0;
                end
            end
            ST_PEND: begin
                if (eof_valid && eof_good) begin
                    wr_en  = 1'b1;
                    wr_ent = '{vld: 1'b1, mac: cur_sa, port: cur_port, age: '0};
                end
            end
            ST_SWEEP: begin
                wr_idx = sw_idx;
                if (rd_a.vld) begin
                    wr_en = 1'b1;
                    if (rd_a.age == AGE_MAX) begin
                        wr_ent.vld = 1'b0;
                    end else begin
                        wr_ent.age = rd_a.age + 1'b1;
                    end
                end
            end
            default: begin
                wr_en = 1'b0;
            end
        endcase
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_flood  <= 1'b0;
            res_filter <= 1'b0;
            res_port   <= '0;
        end else begin
            res_valid <= (state_q == ST_LOOK);
            if (state_q == ST_LOOK) begin
                res_flood  <= look_flood;
                res_filter <= look_filter;
                res_port   <= (look_flood || look_filter) ? '0 : rd_b.port;
            end
        end
    end
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [47:0] req_da,
    input logic        res_valid,
    input logic        res_flood,
    input logic        res_filter
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_RES_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R3
    AST_RES_TWO_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ##1 res_valid); // R3
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R3
    AST_RES_ONLY_IF_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(acc, 2)); // R3
    AST_GROUP_FLOODS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(acc, 2) && $past(req_da[40], 2)) |-> (res_flood && !res_filter)); // R5
    AST_FLOOD_FILTER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_flood && res_filter)); // R6
endmodule

bind mac_learn_table mlt_checker i_mlt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_da     (req_da),
    .res_valid  (res_valid),
    .res_flood  (res_flood),
    .res_filter (res_filter)
);

// File: tb/test_mac_learn_table.sv
`timescale 1ns/1ps
module test_mac_learn_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_sa = '0;
    logic [47:0] req_da = '0;
    logic [2:0]  req_port = '0;
    logic        eof_valid = 1'b0;
    logic        eof_good = 1'b0;
    logic [31:0] age_period = '0;
    logic        res_valid, res_flood, res_filter;
    logic [2:0]  res_port;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mac_learn_table i_mac_learn_table (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sa(req_sa), .req_da(req_da), .req_port(req_port),
        .eof_valid(eof_valid), .eof_good(eof_good), .age_period(age_period),
        .res_valid(res_valid), .res_flood(res_flood), .res_filter(res_filter),
        .res_port(res_port)
    );

    localparam logic [47:0] MAC_A = 48'h00_11_22_33_44_55;
    localparam logic [47:0] MAC_B = 48'h02_aa_bb_cc_dd_01;
    localparam logic [47:0] MAC_C = MAC_A ^ 48'h0000_0000_0401;
    localparam logic [47:0] MAC_D = 48'h00_0d_0d_0d_0d_0d;
    localparam logic [47:0] MAC_Q = 48'h00_77_66_55_44_33;
    localparam logic [47:0] BCAST = 48'hff_ff_ff_ff_ff_ff;
    localparam logic [47:0] MCAST = 48'h01_00_5e_00_00_01;

    function automatic logic [9:0] idx_of(input logic [47:0] m);
        return m[9:0] ^ m[19:10];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one frame: request, result check, optional end-of-frame status
    task automatic frame(input logic [47:0] sa, input logic [47:0] da, input logic [2:0] port,
                         input bit exp_pend, input bit good,
                         input bit e_flood, input bit e_filter, input logic [2:0] e_port,
                         input string tag);
        int guard = 0;
        @(negedge clk);
        while (!req_ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1; req_sa = sa; req_da = da; req_port = port;
        @(negedge clk);
        req_valid = 1'b0;
        chk(res_valid == 1'b0, {tag, " R3 early"}, res_valid, 0);
        chk(req_ready == 1'b0, {tag, " R3 busy"}, req_ready, 0);
        @(negedge clk);
        chk(res_valid == 1'b1, {tag, " R3 due"}, res_valid, 1);
        chk({res_flood, res_filter, res_port} == {e_flood, e_filter, e_port},
            {tag, " result"}, {res_flood, res_filter, res_port}, {e_flood, e_filter, e_port});
        if (exp_pend) begin
            chk(req_ready == 1'b0, {tag, " R7 pend"}, req_ready, 0);
            eof_valid = 1'b1; eof_good = good;
            @(negedge clk);
            eof_valid = 1'b0; eof_good = 1'b0;
            chk(req_ready == 1'b1, {tag, " R7 release"}, req_ready, 1);
        end else begin
            chk(req_ready == 1'b1, {tag, " R9 no wait"}, req_ready, 1);
        end
    endtask

    task automatic wait_sweep();
        int guard = 0;
        @(negedge clk);
        while (req_ready && guard < 5000) begin @(negedge clk); guard++; end
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        chk(guard < 5000, "R10 sweep seen", guard, 0);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        frame(MAC_Q, MAC_A, 3'd0, 1, 0, 1, 0, 3'd0, "R1 empty R5 unknown");
    endtask

    task automatic t_learn();
        frame(MAC_A, BCAST, 3'd2, 1, 1, 1, 0, 3'd0, "R7 learn A R5 bcast");
        frame(MAC_Q, MAC_A, 3'd5, 1, 0, 0, 0, 3'd2, "R7 A found R4");
        frame(MAC_A, MAC_Q, 3'd2, 0, 0, 1, 0, 3'd0, "R9 hit A");
    endtask

    task automatic t_bad_eof();
        frame(MAC_B, MCAST, 3'd3, 1, 0, 1, 0, 3'd0, "R8 bad B R5 mcast");
        frame(MAC_Q, MAC_B, 3'd1, 1, 0, 1, 0, 3'd0, "R8 B absent");
    endtask

    task automatic t_filter();
        frame(MAC_Q, MAC_A, 3'd2, 1, 0, 0, 1, 3'd0, "R6 same port");
    endtask

    task automatic t_collision();
        chk(idx_of(MAC_C) == idx_of(MAC_A), "R2 same index", idx_of(MAC_C), idx_of(MAC_A));
        frame(MAC_C, BCAST, 3'd4, 1, 1, 1, 0, 3'd0, "R2 learn C");
        frame(MAC_Q, MAC_A, 3'd6, 1, 0, 1, 0, 3'd0, "R2 A replaced");
        frame(MAC_Q, MAC_C, 3'd6, 1, 0, 0, 0, 3'd4, "R2 C found");
    endtask

    task automatic t_aging();
        frame(MAC_D, BCAST, 3'd1, 1, 1, 1, 0, 3'd0, "R10 learn D");
        age_period = 32'd16;
        for (int i = 0; i < 3; i++) wait_sweep();
        age_period = 32'd0;
        frame(MAC_Q, MAC_D, 3'd6, 1, 0, 0, 0, 3'd1, "R10 D after 3 sweeps");
        frame(MAC_D, BCAST, 3'd1, 0, 0, 1, 0, 3'd0, "R9 refresh D");
        age_period = 32'd16;
        wait_sweep();
        age_period = 32'd0;
        frame(MAC_Q, MAC_D, 3'd6, 1, 0, 0, 0, 3'd1, "R9 D kept by refresh");
        age_period = 32'd16;
        for (int i = 0; i < 3; i++) wait_sweep();
        age_period = 32'd0;
        frame(MAC_Q, MAC_D, 3'd6, 1, 0, 1, 0, 3'd0, "R10 D aged out");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_learn();
        t_bad_eof();
        t_filter();
        t_collision();
        t_aging();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule